// File: doc/BRIEF.md
# Exception Trap Priority Controller

This block gathers every source of a synchronous exception and picks one to hand to the CPU. The sources are three causes of a system reset, three dedicated hardware traps (non-maskable interrupt, stack overflow and stack underflow), five fault inputs that share one vector, and a software trap strobe that carries a 7-bit trap number. Hardware sources are detected on their rising edge. A software strobe counts as a request in every cycle it is high. Each request stays pending until the CPU acknowledges it.

The chosen request appears as a registered service bundle: the trap number, the vector address (the number times four), a two-bit class and the CPU priority level to force. `svc_req` stays high until the CPU pulses `svc_ack`. If a request of a higher tier arrives first, it takes the place of the one on offer. An eight-bit sticky flag register keeps one bit per hardware trap, so software can still tell apart the faults that share a vector. Software reads these flags and clears them by writing zeros.

Top module: `trap_arbiter`

## Requirements
- R1: After the synchronous reset `rst`, `svc_req` is 0 and `trap_flags` is 0.
- R2: A rising edge on any `rst_cause` bit gives, in the following cycle, `svc_req`=1, number 00h, vector 0, class 0 (reset). This tier beats all others.
- R3: The dedicated traps give class 1: `nmi_req` gives 02h at 0008h, `stk_ovf_req` gives 04h at 0010h, `stk_unf_req` gives 06h at 0018h. When several are pending, they are served in that order.
- R4: A rising edge on any `flt_req` bit gives class 2, number 0Ah, vector 0028h. This tier ranks below class 1.
- R5: `svc_lvl` is 15 for reset, class 1 and class 2 services, and 0 for software traps.
- R6: While `swt_strobe` is high, the trap number `swt_num` (00h to 7Fh) is taken as a pending software trap, and a new strobe overwrites the number. The service has class 3 and vector `swt_num`*4. It is the lowest tier.
- R7: Priority is reset > class 1 > class 2 > class 3. A higher-tier request that arrives while a lower one is on offer replaces it, and `svc_req` stays high.
- R8: `svc_req` stays high until `svc_ack` is sampled high. An acknowledge retires only the source on offer. The next pending source is offered from the cycle after the acknowledge, and `svc_req` drops if none is left.
- R9: `trap_flags` bit 0 is NMI, bit 1 is stack overflow, bit 2 is stack underflow, and bits 3..7 are `flt_req[0..4]`. A flag sets one cycle after its input rises. An acknowledge never clears it.
- R10: When `flag_we` is high, each flag whose `flag_wdata` bit is 0 clears, and each flag whose bit is 1 keeps its value. A rising edge in the same cycle wins over the clear.
- R11: A service with class 0, 1 or 2 never carries a trap number in 0Bh..0Fh.
- R12: A hardware input held high counts as one event. After it is acknowledged, it does not request again until it falls and rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| rst_cause | input | N_RST | Reset causes (hardware, software, watchdog) |
| nmi_req | input | 1 | Non-maskable interrupt trap |
| stk_ovf_req | input | 1 | Stack overflow trap |
| stk_unf_req | input | 1 | Stack underflow trap |
| flt_req | input | N_FLT | Shared-vector faults |
| swt_strobe | input | 1 | Software trap request |
| swt_num | input | 7 | Software trap number |
| flag_we | input | 1 | Flag register write enable |
| flag_wdata | input | 3+N_FLT | Flag write data (0 clears) |
| trap_flags | output | 3+N_FLT | Sticky trap flags |
| svc_ack | input | 1 | CPU acknowledge pulse |
| svc_req | output | 1 | Service request |
| svc_num | output | 7 | Trap number |
| svc_vec | output | VEC_W | Vector address |
| svc_cls | output | 2 | Class: 0 reset, 1 dedicated, 2 shared fault, 3 software |
| svc_lvl | output | 4 | Forced CPU priority level |

## Verification
The hardest case to reach from the ports is a higher-tier edge that lands while a lower request is on offer and not yet acknowledged, together with an acknowledge of the source that was replaced. The stimulus builds this on purpose: it leaves a software trap unacknowledged, raises NMI, and then acknowledges twice. Random phases then mix rare resets, toggling trap inputs, strobes, flag writes and acknowledges, and a bench model tracks every pending bit against them.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NUM_W = 7;

  typedef enum logic [1:0] {
    CLS_RESET = 2'd0,
    CLS_DED   = 2'd1,
    CLS_FLT   = 2'd2,
    CLS_SW    = 2'd3
  } trap_cls_e;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_RST, SRC_NMI, SRC_SOF, SRC_SUF, SRC_FLT, SRC_SWT
  } trap_src_e;

  localparam logic [NUM_W-1:0] NUM_RST = 7'h00;
  localparam logic [NUM_W-1:0] NUM_NMI = 7'h02;
  localparam logic [NUM_W-1:0] NUM_SOF = 7'h04;
  localparam logic [NUM_W-1:0] NUM_SUF = 7'h06;
  localparam logic [NUM_W-1:0] NUM_FLT = 7'h0A;

  typedef struct packed {
    logic             valid;
    trap_src_e        src;
    trap_cls_e        cls;
    logic [NUM_W-1:0] num;
    logic             hw;
  } trap_pick_t;
endpackage

// File: rtl/trap_edge.sv
module trap_edge #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] din_q;

  always_ff @(posedge clk) begin
    if (rst) din_q <= '0;
    else     din_q <= din;
  end

  assign rise = din & ~din_q;
endmodule

// File: rtl/trap_flags.sv
module trap_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags
);
  logic [W-1:0] kept;

  assign kept = we ? (flags & wdata) : flags;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= kept | set;
  end

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
    |set |=> ((flags & $past(set)) == $past(set)));

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (we && set == '0) |=> (flags == ($past(flags) & $past(wdata))));
endmodule

// File: rtl/trap_select.sv
module trap_select
  import trap_pkg::*;
(
  input  logic             p_rst,
  input  logic [2:0]       p_ded,
  input  logic             p_flt,
  input  logic             p_sw,
  input  logic [NUM_W-1:0] sw_num,
  output trap_pick_t       pick
);
  always_comb begin
    pick = '{valid: 1'b1, src: SRC_NONE, cls: CLS_SW, num: '0, hw: 1'b1};
    if (p_rst) begin
      pick.src = SRC_RST; pick.cls = CLS_RESET; pick.num = NUM_RST;
    end else if (p_ded[0]) begin
      pick.src = SRC_NMI; pick.cls = CLS_DED; pick.num = NUM_NMI;
    end else if (p_ded[1]) begin
      pick.src = SRC_SOF; pick.cls = CLS_DED; pick.num = NUM_SOF;
    end else if (p_ded[2]) begin
      pick.src = SRC_SUF; pick.cls = CLS_DED; pick.num = NUM_SUF;
    end else if (p_flt) begin
      pick.src = SRC_FLT; pick.cls = CLS_FLT; pick.num = NUM_FLT;
    end else if (p_sw) begin
      pick.src = SRC_SWT; pick.cls = CLS_SW; pick.num = sw_num; pick.hw = 1'b0;
    end else begin
      pick.valid = 1'b0; pick.hw = 1'b0;
    end
  end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int N_RST = 3,
  parameter int N_FLT = 5,
  parameter int VEC_W = 24,
  parameter int LVL_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_RST-1:0]   rst_cause,
  input  logic               nmi_req,
  input  logic               stk_ovf_req,
  input  logic               stk_unf_req,
  input  logic [N_FLT-1:0]   flt_req,
  input  logic               swt_strobe,
  input  logic [6:0]         swt_num,
  input  logic               flag_we,
  input  logic [3+N_FLT-1:0] flag_wdata,
  output logic [3+N_FLT-1:0] trap_flags,
  input  logic               svc_ack,
  output logic               svc_req,
  output logic [6:0]         svc_num,
  output logic [VEC_W-1:0]   svc_vec,
  output logic [1:0]         svc_cls,
  output logic [LVL_W-1:0]   svc_lvl
);
  localparam int N_DED = 3;
  localparam int N_FLAG = N_DED + N_FLT;
  localparam int N_IN = N_RST + N_FLAG;
  localparam logic [LVL_W-1:0] LVL_TOP = '1;

  logic [N_IN-1:0]  rise;
  logic [N_RST-1:0] rise_rst;
  logic [N_DED-1:0] rise_ded;
  logic [N_FLT-1:0] rise_flt;

  trap_edge #(.W(N_IN)) u_edge (
    .clk (clk),
    .rst (rst),
    .din ({flt_req, stk_unf_req, stk_ovf_req, nmi_req, rst_cause}),
    .rise(rise)
  );

  assign rise_rst = rise[N_RST-1:0];
  assign rise_ded = rise[N_RST +: N_DED];
  assign rise_flt = rise[N_RST+N_DED +: N_FLT];

  trap_flags #(.W(N_FLAG)) u_flags (
    .clk  (clk),
    .rst  (rst),
    .set  ({rise_flt, rise_ded}),
    .we   (flag_we),
    .wdata(flag_wdata),
    .flags(trap_flags)
  );

  logic             p_rst_q, p_flt_q, p_sw_q;
  logic [N_DED-1:0] p_ded_q;
  logic [6:0]       sw_num_q;
  trap_src_e        cur_src;

  logic             take;
  logic             p_rst_n, p_flt_n, p_sw_n;
  logic [N_DED-1:0] p_ded_n;
  logic [6:0]       sw_num_n;
  trap_pick_t       pick;

  assign take = svc_req && svc_ack;

  always_comb begin
    p_rst_n = (p_rst_q && !(take && cur_src == SRC_RST)) || (|rise_rst);
    for (int i = 0; i < N_DED; i++) begin
      p_ded_n[i] = (p_ded_q[i] && !(take && cur_src == trap_src_e'(int'(SRC_NMI) + i)))
                   || rise_ded[i];
    end
    p_flt_n  = (p_flt_q && !(take && cur_src == SRC_FLT)) || (|rise_flt);
    p_sw_n   = (p_sw_q && !(take && cur_src == SRC_SWT)) || swt_strobe;
    sw_num_n = swt_strobe ? swt_num : sw_num_q;
  end

  trap_select u_sel (
    .p_rst (p_rst_n),
    .p_ded (p_ded_n),
    .p_flt (p_flt_n),
    .p_sw  (p_sw_n),
    .sw_num(sw_num_n),
    .pick  (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      p_rst_q  <= 1'b0;
      p_ded_q  <= '0;
      p_flt_q  <= 1'b0;
      p_sw_q   <= 1'b0;
      sw_num_q <= '0;
      cur_src  <= SRC_NONE;
      svc_req  <= 1'b0;
      svc_num  <= '0;
      svc_vec  <= '0;
      svc_cls  <= '0;
      svc_lvl  <= '0;
    end else begin
      p_rst_q  <= p_rst_n;
      p_ded_q  <= p_ded_n;
      p_flt_q  <= p_flt_n;
      p_sw_q   <= p_sw_n;
      sw_num_q <= sw_num_n;
      cur_src  <= pick.src;
      svc_req  <= pick.valid;
      svc_num  <= pick.num;
      svc_vec  <= VEC_W'({pick.num, 2'b00});
      svc_cls  <= pick.cls;
      svc_lvl  <= pick.hw ? LVL_TOP : '0;
    end
  end

  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (svc_req && !svc_ack) |=> svc_req);

  assert_reset_tier_R2: assert property (@(posedge clk) disable iff (rst)
    (|rise_rst) |=> (svc_req && svc_cls == 2'd0 && svc_num == 7'h00));

  assert_no_reserved_R11: assert property (@(posedge clk) disable iff (rst)
    (svc_req && svc_cls != 2'd3) |-> !(svc_num inside {[7'h0B:7'h0F]}));

  assert_hw_level_R5: assert property (@(posedge clk) disable iff (rst)
    (svc_req && svc_cls != 2'd3) |-> (svc_lvl == LVL_TOP));

  assert_replace_R7: assert property (@(posedge clk) disable iff (rst)
    (svc_req && svc_cls == 2'd2 && rise_ded != '0 && rise_rst == '0) |=>
      (svc_req && svc_cls == 2'd1));
endmodule

// File: tb/test_trap_arbiter.sv
module test_trap_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  rst_cause = '0;
  logic        nmi_req = 0, stk_ovf_req = 0, stk_unf_req = 0;
  logic [4:0]  flt_req = '0;
  logic        swt_strobe = 0;
  logic [6:0]  swt_num = '0;
  logic        flag_we = 0;
  logic [7:0]  flag_wdata = '0;
  logic [7:0]  trap_flags;
  logic        svc_ack = 0;
  logic        svc_req;
  logic [6:0]  svc_num;
  logic [23:0] svc_vec;
  logic [1:0]  svc_cls;
  logic [3:0]  svc_lvl;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  trap_arbiter i_trap_arbiter (
    .clk(clk), .rst(rst), .rst_cause(rst_cause), .nmi_req(nmi_req),
    .stk_ovf_req(stk_ovf_req), .stk_unf_req(stk_unf_req), .flt_req(flt_req),
    .swt_strobe(swt_strobe), .swt_num(swt_num), .flag_we(flag_we),
    .flag_wdata(flag_wdata), .trap_flags(trap_flags), .svc_ack(svc_ack),
    .svc_req(svc_req), .svc_num(svc_num), .svc_vec(svc_vec),
    .svc_cls(svc_cls), .svc_lvl(svc_lvl)
  );

  // bench model: sources 0 none,1 reset,2 nmi,3 ovf,4 unf,5 fault,6 software
  bit        m_req, m_prst, m_pflt, m_psw;
  bit [2:0]  m_pded;
  bit [6:0]  m_swn;
  bit [10:0] m_prev;
  bit [7:0]  m_flags;
  int        m_src;

  function automatic bit [6:0] exp_num(int s);
    case (s)
      1: return 7'h00;
      2: return 7'h02;
      3: return 7'h04;
      4: return 7'h06;
      5: return 7'h0A;
      default: return m_swn;
    endcase
  endfunction

  function automatic bit [1:0] exp_cls(int s);
    if (s == 1) return 2'd0;
    if (s >= 2 && s <= 4) return 2'd1;
    if (s == 5) return 2'd2;
    return 2'd3;
  endfunction

  task automatic model_step();
    bit [10:0] in, r;
    if (rst) begin
      m_req = 0; m_prst = 0; m_pflt = 0; m_psw = 0; m_pded = 0;
      m_swn = 0; m_prev = 0; m_flags = 0; m_src = 0;
      return;
    end
    in = {flt_req, stk_unf_req, stk_ovf_req, nmi_req, rst_cause};
    r = in & ~m_prev;
    if (m_req && svc_ack) begin
      case (m_src)
        1: m_prst = 0;
        2: m_pded[0] = 0;
        3: m_pded[1] = 0;
        4: m_pded[2] = 0;
        5: m_pflt = 0;
        6: m_psw = 0;
        default: ;
      endcase
    end
    if (|r[2:0]) m_prst = 1;
    m_pded |= r[5:3];
    if (|r[10:6]) m_pflt = 1;
    if (swt_strobe) begin m_psw = 1; m_swn = swt_num; end
    if (flag_we) m_flags &= flag_wdata;
    m_flags |= r[10:3];
    m_prev = in;
    if (m_prst) m_src = 1;
    else if (m_pded[0]) m_src = 2;
    else if (m_pded[1]) m_src = 3;
    else if (m_pded[2]) m_src = 4;
    else if (m_pflt) m_src = 5;
    else if (m_psw) m_src = 6;
    else m_src = 0;
    m_req = (m_src != 0);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(svc_req == m_req, {tag, " svc_req"}, svc_req, m_req);
    chk(trap_flags == m_flags, {tag, " R9 trap_flags"}, trap_flags, m_flags);
    if (m_req) begin
      chk(svc_num == exp_num(m_src), {tag, " svc_num"}, svc_num, exp_num(m_src));
      chk(svc_vec == {15'd0, exp_num(m_src), 2'b00}, {tag, " svc_vec"},
          svc_vec, {15'd0, exp_num(m_src), 2'b00});
      chk(svc_cls == exp_cls(m_src), {tag, " svc_cls"}, svc_cls, exp_cls(m_src));
      chk(svc_lvl == ((m_src == 6) ? 4'd0 : 4'd15), {tag, " R5 svc_lvl"},
          svc_lvl, (m_src == 6) ? 0 : 15);
      if (svc_cls != 2'd3)
        chk(!(svc_num inside {[7'h0B:7'h0F]}), "R11 reserved number", svc_num, 0);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    cyc("R1"); cyc("R1");
    rst = 0;
    cyc("R1");
    // reset cause
    rst_cause = 3'b010; cyc("R2");
    rst_cause = 3'b000; svc_ack = 1; cyc("R8"); svc_ack = 0;
    // all three dedicated traps together, served in order
    nmi_req = 1; stk_ovf_req = 1; stk_unf_req = 1; cyc("R3");
    svc_ack = 1; cyc("R3"); cyc("R3"); cyc("R8"); svc_ack = 0;
    cyc("R12"); cyc("R12 R9 ack keeps flags");
    nmi_req = 0; stk_ovf_req = 0; stk_unf_req = 0;
    // partial clear, then set wins over clear
    flag_we = 1; flag_wdata = 8'hFE; cyc("R10");
    flag_wdata = 8'h00; flt_req[0] = 1; cyc("R10 R4"); flag_we = 0;
    flt_req[0] = 0; svc_ack = 1; cyc("R8"); svc_ack = 0;
    // software trap at the top of the range
    swt_strobe = 1; swt_num = 7'h7F; cyc("R6"); swt_strobe = 0; cyc("R6");
    nmi_req = 1; cyc("R7");
    svc_ack = 1; cyc("R7 R8"); cyc("R8"); svc_ack = 0; nmi_req = 0;
    // fault tier vs software tier and reset tier
    swt_strobe = 1; swt_num = 7'h0C; flt_req = 5'b10110; cyc("R4 R7");
    swt_strobe = 0; rst_cause = 3'b100; cyc("R2 R7");
    rst_cause = 0; flt_req = 0; svc_ack = 1; cyc("R8"); cyc("R8"); cyc("R6 R11");
    svc_ack = 0;
    // random phase
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 63) == 0) rst_cause = 3'($urandom);
      else rst_cause = 0;
      if ($urandom_range(0, 7) == 0) nmi_req = ~nmi_req;
      if ($urandom_range(0, 7) == 0) stk_ovf_req = ~stk_ovf_req;
      if ($urandom_range(0, 7) == 0) stk_unf_req = ~stk_unf_req;
      if ($urandom_range(0, 3) == 0) flt_req = flt_req ^ 5'($urandom);
      swt_strobe = ($urandom_range(0, 9) == 0);
      swt_num = 7'($urandom);
      flag_we = ($urandom_range(0, 15) == 0);
      flag_wdata = 8'($urandom);
      svc_ack = ($urandom_range(0, 2) == 0);
      rst = ($urandom_range(0, 999) == 0);
      cyc("R7 random");
    end
    rst = 0;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule